// File: doc/BRIEF.md
# PLL Lock Supervisor Register

This block is the status and control register that sits beside a clock generator's phase-locked loop. It carries the live lock indication from the analog loop into the register clock domain through a two-flop synchronizer, and it holds a sticky flag that records any loss of lock. A change of the feedback-divider setting also counts as a loss of lock, because the loop must reacquire after such a change. Two enable bits decide whether a loss of lock raises an interrupt request, a device reset request, or both.

The block also checks the divider settings against their legal ranges and flags a configuration error. A loss-of-lock reset clears this register along with the rest of the device. For that reason the block emits a separate cause pulse, so that an external reset status register can record why the reset happened. Software reads and writes the register through a simple 32-bit port. Read data is registered.

Top module: `pll_lock_ctrl`

## Requirements
- R1: During and after a synchronous reset, every output is 0 and the register reads as all zeros.
- R2: Bits 31 to 4 read as 0, and writes to them have no effect.
- R3: Bit 1 reads the PLL lock input (1 = locked) after it has passed a two-stage synchronizer. It cannot be written.
- R4: Bit 0, the lost-lock flag, is set when the synchronized lock falls from 1 to 0.
- R5: Bit 0 is also set when the feedback-divider input changes value. A change is only seen from the second cycle after reset.
- R6: Writing 1 to bit 0 clears the flag and writing 0 leaves it unchanged. A set event in the same cycle as a clear wins, so the flag stays 1.
- R7: Bit 2 (interrupt enable) and bit 3 (reset enable) are read/write and take the value written.
- R8: lol_irq is a registered level equal to the flag AND bit 2. It falls in the cycle the flag clears.
- R9: lol_rst_req is a one-cycle pulse. It fires when a set event finds the flag clear while bit 3 is 1. No pulse occurs when the flag is already set.
- R10: lol_rst_cause pulses in exactly the same cycles as lol_rst_req.
- R11: cfg_err is registered and is 1 when the feedback divider lies outside 4 to 34 or the output divider lies outside 1 to 15.
- R12: reg_rdata is updated one cycle after a cycle with reg_rd high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pll_lock_async | input | 1 | Lock indication from the analog loop, asynchronous |
| fb_div | input | 6 | Current feedback-divider setting |
| out_div | input | 4 | Current output-divider setting |
| lol_irq | output | 1 | Loss-of-lock interrupt request (level) |
| lol_rst_req | output | 1 | Loss-of-lock device reset request (pulse) |
| lol_rst_cause | output | 1 | Reset-cause pulse for an external status register |
| cfg_err | output | 1 | Divider setting out of range |

## Verification
The hardest case to reach is a set event that lands on the same clock edge as a software clear. The lock path sits behind three registers, so the bench does not use it for this case. Instead it changes the feedback divider and writes 1 to bit 0 on the same drive edge, which makes the divider comparison and the clear meet on the next edge. A second hard case is a lock drop while the flag is already set, which must produce no reset pulse. The bench reaches it by dropping lock twice without clearing the flag in between.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  localparam int BIT_FLAG  = 0;
  localparam int BIT_LOCK  = 1;
  localparam int BIT_IRQEN = 2;
  localparam int BIT_RSTEN = 3;
  localparam int CTRL_W    = 4;

  typedef struct packed {
    logic rst_en;
    logic irq_en;
    logic lock;
    logic flag;
  } stat_t;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pll_lol_detect.sv
module pll_lol_detect #(
  parameter int FB_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lock_s,
  input  logic [FB_W-1:0] fb_div,
  input  logic            flag_q,
  output logic            set_evt,
  output logic            new_evt
);
  logic            lock_d;
  logic [FB_W-1:0] fb_q;
  logic            fb_vld;
  logic            fall;
  logic            div_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_d <= 1'b0;
      fb_q   <= '0;
      fb_vld <= 1'b0;
    end else begin
      lock_d <= lock_s;
      fb_q   <= fb_div;
      fb_vld <= 1'b1;
    end
  end

  always_comb begin
    fall    = lock_d & ~lock_s;
    div_chg = fb_vld & (fb_q != fb_div);
    set_evt = fall | div_chg;
    new_evt = set_evt & ~flag_q;
  end
endmodule

// File: rtl/pll_div_check.sv
module pll_div_check #(
  parameter int FB_W   = 6,
  parameter int OD_W   = 4,
  parameter int FB_MIN = 4,
  parameter int FB_MAX = 34,
  parameter int OD_MIN = 1,
  parameter int OD_MAX = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FB_W-1:0] fb_div,
  input  logic [OD_W-1:0] out_div,
  output logic            cfg_err
);
  localparam logic [FB_W-1:0] FB_LO = FB_W'(FB_MIN);
  localparam logic [FB_W-1:0] FB_HI = FB_W'(FB_MAX);
  localparam logic [OD_W-1:0] OD_LO = OD_W'(OD_MIN);
  localparam logic [OD_W-1:0] OD_HI = OD_W'(OD_MAX);

  logic bad;
  always_comb begin
    bad = (fb_div < FB_LO) | (fb_div > FB_HI) | (out_div < OD_LO) | (out_div > OD_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= bad;
  end
endmodule

// File: rtl/pll_stat_regs.sv
module pll_stat_regs
  import pll_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              lock_s,
  input  logic              set_evt,
  input  logic              new_evt,
  output logic              flag_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              lol_irq,
  output logic              lol_rst_req,
  output logic              lol_rst_cause
);
  localparam int RSV_W = DATA_W - CTRL_W;

  logic  irq_en_q, rst_en_q;
  logic  flag_n, irq_en_n, rst_en_n;
  stat_t view;
  logic  unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:CTRL_W] ^ reg_wdata[BIT_LOCK];

  always_comb begin
    flag_n   = flag_q;
    irq_en_n = irq_en_q;
    rst_en_n = rst_en_q;
    if (reg_wr) begin
      irq_en_n = reg_wdata[BIT_IRQEN];
      rst_en_n = reg_wdata[BIT_RSTEN];
      if (reg_wdata[BIT_FLAG]) flag_n = 1'b0;
    end
    if (set_evt) flag_n = 1'b1;
    view.rst_en = rst_en_q;
    view.irq_en = irq_en_q;
    view.lock   = lock_s;
    view.flag   = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q        <= 1'b0;
      irq_en_q      <= 1'b0;
      rst_en_q      <= 1'b0;
      lol_irq       <= 1'b0;
      lol_rst_req   <= 1'b0;
      lol_rst_cause <= 1'b0;
      reg_rdata     <= '0;
    end else begin
      flag_q        <= flag_n;
      irq_en_q      <= irq_en_n;
      rst_en_q      <= rst_en_n;
      lol_irq       <= flag_n & irq_en_n;
      lol_rst_req   <= new_evt & rst_en_q;
      lol_rst_cause <= new_evt & rst_en_q;
      if (reg_rd) reg_rdata <= {{RSV_W{1'b0}}, view};
    end
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag_q);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[BIT_FLAG] && !set_evt) |=> !flag_q);
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
    lol_irq |-> flag_q);
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    lol_rst_req |=> !lol_rst_req);
  p_cause_match_r10: assert property (@(posedge clk) disable iff (rst)
    lol_rst_req == lol_rst_cause);
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:CTRL_W] == '0);
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl #(
  parameter int DATA_W      = 32,
  parameter int FB_W        = 6,
  parameter int OD_W        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FB_MIN      = 4,
  parameter int FB_MAX      = 34,
  parameter int OD_MIN      = 1,
  parameter int OD_MAX      = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pll_lock_async,
  input  logic [FB_W-1:0]   fb_div,
  input  logic [OD_W-1:0]   out_div,
  output logic              lol_irq,
  output logic              lol_rst_req,
  output logic              lol_rst_cause,
  output logic              cfg_err
);
  logic lock_s, set_evt, new_evt, flag_q;

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pll_lock_async), .sync_out(lock_s));

  pll_lol_detect #(.FB_W(FB_W)) u_detect (
    .clk(clk), .rst(rst), .lock_s(lock_s), .fb_div(fb_div), .flag_q(flag_q),
    .set_evt(set_evt), .new_evt(new_evt));

  pll_div_check #(.FB_W(FB_W), .OD_W(OD_W), .FB_MIN(FB_MIN), .FB_MAX(FB_MAX),
                  .OD_MIN(OD_MIN), .OD_MAX(OD_MAX)) u_chk (
    .clk(clk), .rst(rst), .fb_div(fb_div), .out_div(out_div), .cfg_err(cfg_err));

  pll_stat_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .lock_s(lock_s), .set_evt(set_evt), .new_evt(new_evt), .flag_q(flag_q),
    .reg_rdata(reg_rdata), .lol_irq(lol_irq), .lol_rst_req(lol_rst_req),
    .lol_rst_cause(lol_rst_cause));

  p_no_req_when_set_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(reg_wr && reg_wdata[0])) |=> !lol_rst_req);
endmodule

// File: tb/test_pll_lock_ctrl.sv
module test_pll_lock_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pll_lock_async = 1'b0;
  logic [5:0]  fb_div = 6'd10;
  logic [3:0]  out_div = 4'd2;
  logic        lol_irq, lol_rst_req, lol_rst_cause, cfg_err;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pll_lock_ctrl i_pll_lock_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pll_lock_async(pll_lock_async), .fb_div(fb_div),
    .out_div(out_div), .lol_irq(lol_irq), .lol_rst_req(lol_rst_req),
    .lol_rst_cause(lol_rst_cause), .cfg_err(cfg_err));

  // behavioural reference model
  bit sync_q[$];
  bit m_lockd, m_fbv, m_flag, m_irqen, m_rsten;
  bit m_irq, m_rreq, m_cfg;
  int m_fbq;
  logic [31:0] m_rdata;

  function automatic bit m_lock();
    return sync_q[1];
  endfunction

  initial begin
    sync_q = '{0, 0};
  end

  always @(posedge clk) begin
    bit fall, chg, setv, newev, nflag, nirq, nrst;
    if (rst) begin
      sync_q = '{0, 0};
      m_lockd = 0; m_fbv = 0; m_fbq = 0; m_flag = 0; m_irqen = 0; m_rsten = 0;
      m_irq = 0; m_rreq = 0; m_cfg = 0; m_rdata = 0;
    end else begin
      fall  = m_lockd && !m_lock();
      chg   = m_fbv && (m_fbq != int'(fb_div));
      setv  = fall || chg;
      newev = setv && !m_flag;
      nflag = m_flag; nirq = m_irqen; nrst = m_rsten;
      if (reg_wr) begin
        nirq = reg_wdata[2];
        nrst = reg_wdata[3];
        if (reg_wdata[0]) nflag = 0;
      end
      if (setv) nflag = 1;
      m_rreq = newev && m_rsten;
      m_irq  = nflag && nirq;
      m_cfg  = (fb_div < 4) || (fb_div > 34) || (out_div < 1) || (out_div > 15);
      if (reg_rd) m_rdata = {28'd0, m_rsten, m_irqen, m_lock(), m_flag};
      m_lockd = m_lock();
      sync_q.push_front(pll_lock_async);
      void'(sync_q.pop_back());
      m_fbq = int'(fb_div); m_fbv = 1;
      m_flag = nflag; m_irqen = nirq; m_rsten = nrst;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R8 lol_irq", {31'd0, lol_irq}, {31'd0, m_irq});
      check("R9 lol_rst_req", {31'd0, lol_rst_req}, {31'd0, m_rreq});
      check("R10 lol_rst_cause", {31'd0, lol_rst_cause}, {31'd0, m_rreq});
      check("R11 cfg_err", {31'd0, cfg_err}, {31'd0, m_cfg});
      check("R12 reg_rdata", reg_rdata, m_rdata);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(output logic [31:0] d);
    reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  initial begin
    #(5.0 * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    cyc(3);
    // R1: reset state
    check("R1 outputs in reset", {28'd0, lol_irq, lol_rst_req, lol_rst_cause, cfg_err}, 32'd0);
    rst = 0;
    cyc(1);
    rd(d); check("R1 register after reset", d, 32'd0);

    // R3: lock visible after synchronizer
    pll_lock_async = 1; cyc(3);
    rd(d); check("R3 lock bit", d, 32'h2);

    // R7, R2: enables and reserved bits
    wr(32'hFFFF_FFF4); rd(d); check("R2 R7 irq enable only", d, 32'h6);
    wr(32'h0000_000C); rd(d); check("R7 both enables", d, 32'hE);
    wr(32'h0000_0004);

    // R4, R8: lock drop sets flag and irq
    pll_lock_async = 0; cyc(4);
    check("R8 irq after drop", {31'd0, lol_irq}, 32'd1);
    rd(d); check("R4 flag after drop", d, 32'h5);

    // R6: write 0 no effect, write 1 clears
    wr(32'h0000_0004); rd(d); check("R6 write0 keeps flag", d, 32'h5);
    wr(32'h0000_0005); check("R8 irq drops on clear", {31'd0, lol_irq}, 32'd0);
    rd(d); check("R6 write1 clears", d, 32'h4);

    // R9, R10: reset pulse on new event
    wr(32'h0000_0008);
    pll_lock_async = 1; cyc(4);
    pll_lock_async = 0; cyc(3);
    check("R9 rst_req pulse", {31'd0, lol_rst_req}, 32'd1);
    check("R10 cause pulse", {31'd0, lol_rst_cause}, 32'd1);
    cyc(1); check("R9 pulse one cycle", {31'd0, lol_rst_req}, 32'd0);

    // R9: second drop while flag set gives no pulse
    pll_lock_async = 1; cyc(4);
    pll_lock_async = 0; cyc(6);
    rd(d); check("R9 flag still set, enables kept", d, 32'h9);

    // R5: divider change sets flag
    wr(32'h0000_0009); rd(d); check("R6 clear", d, 32'h8);
    fb_div = 6'd12; cyc(2);
    rd(d); check("R5 divider change", d, 32'h9);

    // R6: set wins over simultaneous clear
    fb_div = 6'd14; reg_wr = 1; reg_wdata = 32'h1;
    cyc(1); reg_wr = 0; reg_wdata = 0;
    rd(d); check("R6 set beats clear", d, 32'h1);

    // R11: range checks
    fb_div = 6'd3;  cyc(2); check("R11 fb low", {31'd0, cfg_err}, 32'd1);
    fb_div = 6'd4;  cyc(2); check("R11 fb min ok", {31'd0, cfg_err}, 32'd0);
    fb_div = 6'd34; cyc(2); check("R11 fb max ok", {31'd0, cfg_err}, 32'd0);
    fb_div = 6'd35; cyc(2); check("R11 fb high", {31'd0, cfg_err}, 32'd1);
    fb_div = 6'd20; out_div = 4'd0; cyc(2); check("R11 od zero", {31'd0, cfg_err}, 32'd1);
    out_div = 4'd15; cyc(2); check("R11 od max ok", {31'd0, cfg_err}, 32'd0);

    // R12: rdata holds without read strobe
    wr(32'h1); cyc(2);
    check("R12 rdata hold", reg_rdata, 32'h1);

    // R1: reset clears everything again
    wr(32'hC); rst = 1; cyc(2);
    check("R1 reset clears", {28'd0, lol_irq, lol_rst_req, lol_rst_cause, cfg_err}, 32'd0);
    rst = 0; cyc(1);
    rd(d); check("R1 reg cleared", d, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule